// File: doc/BRIEF.md
# Four-Voice Square-Wave Tone Generator

This block makes up to four independent square-wave audio tones. All voices share one slow tick. A prescaler divides a base-rate strobe (`base_en`) down to that tick. With the default ratio of 256 and a 5 MHz strobe, the tick rate is 19531.25 per second.

Each voice holds an 8-bit half-period value and a live down-counter. On every tick where the voice is enabled, its counter steps down by one. When the counter would reach zero, the voice reloads it and flips its output. A reload value of N therefore holds each output level for N ticks:

- N = 1 flips the output on every tick.
- N = 255 gives the slowest tone, about 76.6 flips per second at the default rate.

Software loads a note by writing a value to one voice. The write sets the stored value and the live counter together. A per-voice enable mask freezes voices that are not playing. The speaker line merges the enabled voices.

Top module: `quad_tone`

## Requirements
- R1: A synchronous reset clears every tone output, the speaker line, all stored half-period values, all counters and the enable mask. After reset, no voice moves on a tick until its mask bit is set.
- R2: The tick fires once for every PRESC cycles in which `base_en` is high. With PRESC = 1, every `base_en` cycle is a tick.
- R3: A write (`wr_en` high) to voice `wr_chan` loads `wr_value` into both that voice's stored value and its counter at the clock edge. If a tick arrives in the same cycle, the write wins: the counter takes the written value and the output does not flip.
- R4: An enabled voice with stored value N (1 to 255) inverts its output on every Nth tick after its counter was last loaded. N = 1 inverts on every tick; N = 255 inverts every 255 ticks.
- R5: Mask bit i enables voice i. The mask is loaded from `mask_value` when `mask_we` is high. While a voice's bit is 0, its counter and its output hold, and counting resumes from the held count when the bit returns to 1.
- R6: A stored value of 0 silences the voice. Its output is low from the edge of that write and stays low on every following tick.
- R7: `spk` is high exactly when at least one voice whose mask bit is 1 has its output high. A high output on a masked-off voice does not reach `spk`.
- R8: Voices are independent: ticks, writes and values on one voice do not alter any other voice.
- R9: Writing a non-zero value does not change the voice's current output level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| base_en | input | 1 | Base-rate strobe counted by the prescaler |
| wr_en | input | 1 | Load a half-period value into one voice |
| wr_chan | input | 2 | Voice selected by a write |
| wr_value | input | 8 | Half-period in ticks; 0 silences the voice |
| mask_we | input | 1 | Load the enable mask |
| mask_value | input | 4 | New enable mask, bit i for voice i |
| tone | output | 4 | Square-wave output of each voice |
| spk | output | 1 | Merged speaker drive |

## Verification
A corrupted counter or stored value shows at the ports as a misplaced edge on that voice's `tone` bit. The edge comes early or late by the size of the error, so it is seen within at most 255 ticks of the fault. A lost freeze or a lost write priority shows as an extra inversion on the very tick that should have been suppressed. A wrong mask shows at once on `spk`, whenever a frozen voice sits high.

// File: rtl/quad_tone_pkg.sv
package quad_tone_pkg;
    localparam int unsigned QT_VOICES = 4;
    localparam int unsigned QT_WIDTH  = 8;
    localparam int unsigned QT_PRESC  = 256;
endpackage

// File: rtl/qt_ticker.sv
module qt_ticker #(
    parameter int unsigned PRESC = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic base_en,
    output logic tick
);
    localparam int unsigned CW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tk_t;

    tk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = base_en && (st_q.cnt == LAST);
        if (base_en) begin
            if (st_q.cnt == LAST) st_d.cnt = '0;
            else                  st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/qt_voice.sv
module qt_voice #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             load,
    input  logic [WIDTH-1:0] value,
    output logic             level
);
    typedef struct packed {
        logic [WIDTH-1:0] reload;
        logic [WIDTH-1:0] count;
        logic             level;
    } vs_t;

    vs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            // new note: stored value and live counter together, write beats tick
            st_d.reload = value;
            st_d.count  = value;
            if (value == '0) st_d.level = 1'b0;
        end else if (tick && run) begin
            if (st_q.reload == '0) begin
                st_d.level = 1'b0;
            end else if (st_q.count <= WIDTH'(1)) begin
                st_d.count = st_q.reload;
                st_d.level = ~st_q.level;
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign level = st_q.level;
endmodule

// File: rtl/quad_tone.sv
module quad_tone #(
    parameter int unsigned CHANS = quad_tone_pkg::QT_VOICES,
    parameter int unsigned WIDTH = quad_tone_pkg::QT_WIDTH,
    parameter int unsigned PRESC = quad_tone_pkg::QT_PRESC,
    localparam int unsigned CW   = (CHANS > 1) ? $clog2(CHANS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             base_en,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_chan,
    input  logic [WIDTH-1:0] wr_value,
    input  logic             mask_we,
    input  logic [CHANS-1:0] mask_value,
    output logic [CHANS-1:0] tone,
    output logic             spk
);
    logic             tick;
    logic [CHANS-1:0] mask_d, mask_q;

    qt_ticker #(.PRESC(PRESC)) u_ticker (
        .clk     (clk),
        .rst     (rst),
        .base_en (base_en),
        .tick    (tick)
    );

    always_comb begin
        mask_d = mask_q;
        if (mask_we) mask_d = mask_value;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end

    for (genvar i = 0; i < CHANS; i++) begin : g_voice
        qt_voice #(.WIDTH(WIDTH)) u_voice (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick),
            .run   (mask_q[i]),
            .load  (wr_en && (wr_chan == CW'(i))),
            .value (wr_value),
            .level (tone[i])
        );
    end

    assign spk = |(tone & mask_q);
endmodule

// File: rtl/quad_tone_chk.sv
module quad_tone_chk #(
    parameter int unsigned CHANS = 4,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned CW   = (CHANS > 1) ? $clog2(CHANS) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [CHANS-1:0] mask_q,
    input logic             wr_en,
    input logic [CW-1:0]    wr_chan,
    input logic [WIDTH-1:0] wr_value,
    input logic [CHANS-1:0] tone,
    input logic             spk
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (tone == '0 && !spk));

    p_spk_source_r7: assert property (@(posedge clk) disable iff (rst)
        spk |-> (tone != '0));

    p_spk_masked_r7: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !spk);

    for (genvar i = 0; i < CHANS; i++) begin : g_chk
        p_move_cause_r4: assert property (@(posedge clk) disable iff (rst)
            !$stable(tone[i]) |-> $past((tick && mask_q[i]) || (wr_en && wr_chan == CW'(i))));

        p_frozen_r5: assert property (@(posedge clk) disable iff (rst)
            (!mask_q[i] && !(wr_en && wr_chan == CW'(i))) |=> $stable(tone[i]));

        p_silence_r6: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_chan == CW'(i) && wr_value == '0) |=> !tone[i]);

        p_write_keeps_r9: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_chan == CW'(i) && wr_value != '0) |=> $stable(tone[i]));
    end
endmodule

bind quad_tone quad_tone_chk #(.CHANS(CHANS), .WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .mask_q   (mask_q),
    .wr_en    (wr_en),
    .wr_chan  (wr_chan),
    .wr_value (wr_value),
    .tone     (tone),
    .spk      (spk)
);

// File: tb/quad_tone_tb_top.sv
module quad_tone_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       base_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_chan = '0;
    logic [7:0] wr_value = '0;
    logic       mask_we = 1'b0;
    logic [3:0] mask_value = '0;
    logic [3:0] tone, tone_p;
    logic       spk, spk_p;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    quad_tone #(.PRESC(1)) dut_i (
        .clk(clk), .rst(rst), .base_en(base_en), .wr_en(wr_en),
        .wr_chan(wr_chan), .wr_value(wr_value), .mask_we(mask_we),
        .mask_value(mask_value), .tone(tone), .spk(spk)
    );

    quad_tone #(.PRESC(4)) dut_p (
        .clk(clk), .rst(rst), .base_en(1'b1), .wr_en(wr_en),
        .wr_chan(wr_chan), .wr_value(wr_value), .mask_we(mask_we),
        .mask_value(mask_value), .tone(tone_p), .spk(spk_p)
    );

    typedef struct packed {
        logic [1:0] ch;
        logic [7:0] v;
        logic [7:0] n;
        logic       e;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{2'd0, 8'd1,   8'd1,   1'b1},
        '{2'd1, 8'd1,   8'd2,   1'b0},
        '{2'd2, 8'd1,   8'd3,   1'b1},
        '{2'd3, 8'd3,   8'd2,   1'b0},
        '{2'd0, 8'd3,   8'd3,   1'b1},
        '{2'd1, 8'd3,   8'd6,   1'b0},
        '{2'd2, 8'd4,   8'd9,   1'b0},
        '{2'd3, 8'd5,   8'd5,   1'b1},
        '{2'd0, 8'd255, 8'd254, 1'b0},
        '{2'd1, 8'd255, 8'd255, 1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] c, input logic [7:0] v);
        wr_en = 1'b1; wr_chan = c; wr_value = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mask(input logic [3:0] m);
        mask_we = 1'b1; mask_value = m;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            base_en = 1'b1;
            @(negedge clk);
            base_en = 1'b0;
        end
    endtask

    task automatic gap_p0(output int gap);
        logic prev;
        int   w;
        prev = tone_p[0];
        w = 0;
        while (tone_p[0] == prev && w < 100) begin @(negedge clk); w++; end
        prev = tone_p[0];
        gap = 0;
        while (tone_p[0] == prev && gap < 100) begin @(negedge clk); gap++; end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int gap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: cleared outputs
        check(tone == 4'b0, "R1 tone after reset", tone, 0);
        check(spk == 1'b0, "R1 spk after reset", spk, 0);
        // R1: mask cleared, loaded voice does not move
        put(2'd0, 8'd1);
        ticks(1);
        check(tone[0] == 1'b0, "R1 mask cleared", tone[0], 0);
        // R1: stored values cleared, enabled voices stay silent
        set_mask(4'b1111);
        put(2'd0, 8'd0);
        ticks(2);
        check(tone == 4'b0, "R1 reload cleared", tone, 0);

        // R4: table of values and tick counts
        foreach (VEC[k]) begin
            put(VEC[k].ch, 8'd0);
            put(VEC[k].ch, VEC[k].v);
            ticks(int'(VEC[k].n));
            check(tone[VEC[k].ch] == VEC[k].e, "R4 half-period table",
                  tone[VEC[k].ch], VEC[k].e);
        end

        // clear all voices
        for (int c = 0; c < 4; c++) put(2'(c), 8'd0);

        // R3: write and tick in the same cycle, write wins
        put(2'd1, 8'd3);
        ticks(2);
        wr_en = 1'b1; wr_chan = 2'd1; wr_value = 8'd3; base_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; base_en = 1'b0;
        check(tone[1] == 1'b0, "R3 write beats tick", tone[1], 0);
        ticks(2);
        check(tone[1] == 1'b0, "R3 counter reloaded", tone[1], 0);
        ticks(1);
        check(tone[1] == 1'b1, "R3 flip after full count", tone[1], 1);
        // R9: non-zero write keeps level
        put(2'd1, 8'd5);
        check(tone[1] == 1'b1, "R9 write keeps level", tone[1], 1);
        put(2'd1, 8'd0);

        // R5 / R7: freeze a high voice
        put(2'd2, 8'd2);
        ticks(2);
        check(tone[2] == 1'b1, "R5 setup high", tone[2], 1);
        set_mask(4'b1011);
        ticks(5);
        check(tone[2] == 1'b1, "R5 frozen output", tone[2], 1);
        check(spk == 1'b0, "R7 masked voice off speaker", spk, 0);
        set_mask(4'b1111);
        check(spk == 1'b1, "R7 unmasked voice on speaker", spk, 1);
        ticks(1);
        check(tone[2] == 1'b1, "R5 count held while frozen", tone[2], 1);
        ticks(1);
        check(tone[2] == 1'b0, "R5 resume from held count", tone[2], 0);

        // R6: silence forces low
        ticks(2);
        check(tone[2] == 1'b1, "R6 setup high", tone[2], 1);
        put(2'd2, 8'd0);
        check(tone[2] == 1'b0, "R6 low at write", tone[2], 0);
        ticks(3);
        check(tone[2] == 1'b0, "R6 stays low", tone[2], 0);

        // R8: independent voices
        put(2'd0, 8'd1);
        put(2'd3, 8'd3);
        ticks(3);
        check(tone == 4'b1001, "R8 both voices", tone, 9);
        check(spk == 1'b1, "R7 speaker high", spk, 1);
        ticks(1);
        check(tone == 4'b1000, "R8 fast voice flips alone", tone, 8);

        // R2: prescaler of 4 on the second instance
        put(2'd0, 8'd1);
        gap_p0(gap);
        check(gap == 4, "R2 prescale 4 with N=1", gap, 4);
        put(2'd0, 8'd2);
        gap_p0(gap);
        check(gap == 8, "R2 prescale 4 with N=2", gap, 8);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule